// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block derives an SPI serial clock (SCK) from the system clock. A 32-bit clock configuration word sets the length of one SCK period through a 6-bit divider field, and the length of the high phase through a separate 6-bit high-count field. Because the high phase is set apart from the period, the duty cycle can be asymmetric rather than a fixed divide-by-two toggle. Bit 31 of the word holds a clock source selection, and bits [5:0] hold a low-count field. The block does not use either of them to shape the clock; the low phase is simply the rest of the period.

A transfer engine raises `runReq` for as long as it wants SCK to run. The block returns two single-cycle strobes. `shiftStb` marks the leading edge, where the engine launches the next bit. `captureStb` marks the trailing edge, where it samples incoming data. When no run is active, SCK sits at a programmable idle level. While a run is active, a polarity control can invert SCK. The divider and high count are captured when a run starts, so software may rewrite the configuration word while a run is in progress.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset the generator is not running, `sck` equals `idleHigh`, and both strobes are low.
- R2: While running, one SCK period lasts divider+1 system clocks. The divider is `clkCfg[17:12]`, and a divider of 0 is treated as 1. Each new run restarts the period count at 0.
- R3: In each period the uninverted clock is high for counts 0 through the high count, `clkCfg[11:6]`, and low for the remaining counts of the period.
- R4: If the high count is at least the effective divider, it is clamped to the divider minus 1. This leaves at least one low cycle in every period.
- R5: `shiftStb` is high for exactly the one cycle in which the count is 0. `captureStb` is high for exactly the one cycle in which the count is the high count plus 1. The two strobes never overlap.
- R6: While running, `sck` follows the uninverted clock when `clkNotInv` is 1 and its complement when `clkNotInv` is 0.
- R7: While not running, `sck` equals `idleHigh`. In the cycle after `runReq` is sampled low during a run, the block stops running and `sck` returns to that level.
- R8: The divider and high count are captured on the clock edge at which a run starts. Changes to `clkCfg` during a run have no effect on `sck` or the strobes until the next run.
- R9: `clkCfg[31]` (source select) and `clkCfg[5:0]` (low count) have no effect on any output.
- R10: On the first cycle after `runReq` is sampled high from idle, the count is 0. `shiftStb` is high and `sck` shows the uninverted high level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkCfg | input | 32 | Clock configuration word (divider, high count, low count, source select) |
| runReq | input | 1 | High while the transfer engine wants SCK to run |
| clkNotInv | input | 1 | 1: SCK is not inverted while running; 0: SCK is inverted |
| idleHigh | input | 1 | SCK level while not running |
| sck | output | 1 | Serial clock |
| shiftStb | output | 1 | One-cycle strobe on the SCK leading edge |
| captureStb | output | 1 | One-cycle strobe on the SCK trailing edge |

## Verification
The assertions assume that a run can start only from the idle state. They also assume that the captured high count is below the captured divider, and that the count stays at or below the divider. The clamp and the start condition establish these in the design, so the assertions hold for any configuration word. The stimulus drives every input half a cycle away from the sampling edge and keeps the polarity controls steady within each test phase. It covers divider 0, equal and oversized high counts, asymmetric duty, early stops and restarts, and configuration rewrites, including bit 31, during a run. A behavioural model in the bench predicts `sck` and both strobes and is compared with the outputs on every cycle.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  // control to datapath strobes
  typedef struct packed {
    logic start;   // run begins on this edge: capture config, clear count
    logic active;  // generator is running this cycle
  } clkCtl_t;
endpackage

// File: rtl/spi_sck_ctrl.sv
module spi_sck_ctrl
  import spiclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    runReq,
  output clkCtl_t ctl
);
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= runReq;
  end

  always_comb begin
    ctl.start  = runReq && !running;
    ctl.active = running;
  end

  // a run start is a single cycle: the next cycle is already running
  a_r10_start_single: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> (ctl.active && !ctl.start));
  // stop takes effect one cycle after the request drops
  a_r7_stop_next: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !runReq) |=> !ctl.active);
endmodule

// File: rtl/spi_sck_datapath.sv
module spi_sck_datapath
  import spiclk_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CFG_W  = 32,
  parameter int DIV_LSB = 12,
  parameter int HI_LSB  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] clkCfg,
  input  clkCtl_t          ctl,
  output logic             rawSck,
  output logic             shiftStb,
  output logic             captureStb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] divField, hiField, divEff, hiEff;
  logic [CNT_W-1:0] divQ, hiQ, cnt;

  assign divField = clkCfg[DIV_LSB +: CNT_W];
  assign hiField  = clkCfg[HI_LSB  +: CNT_W];

  // divider 0 acts as 1; high count clamped to leave one low cycle
  always_comb begin
    divEff = (divField == '0) ? ONE : divField;
    hiEff  = (hiField >= divEff) ? (divEff - ONE) : hiField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= ONE;
      hiQ  <= '0;
      cnt  <= '0;
    end else if (ctl.start) begin
      divQ <= divEff;
      hiQ  <= hiEff;
      cnt  <= '0;
    end else if (ctl.active) begin
      cnt <= (cnt == divQ) ? '0 : cnt + ONE;
    end
  end

  assign rawSck     = (cnt <= hiQ);
  assign shiftStb   = ctl.active && (cnt == '0);
  assign captureStb = ctl.active && (cnt == hiQ + ONE);

  a_r4_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (hiQ < divQ));
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (cnt <= divQ));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && cnt == divQ) |=> (cnt == '0));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> ($stable(divQ) && $stable(hiQ)));
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftStb && captureStb));
  a_r10_first_shift: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> (shiftStb && rawSck));
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spiclk_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int CFG_W   = 32,
  parameter int DIV_LSB = 12,
  parameter int HI_LSB  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] clkCfg,
  input  logic             runReq,
  input  logic             clkNotInv,
  input  logic             idleHigh,
  output logic             sck,
  output logic             shiftStb,
  output logic             captureStb
);
  clkCtl_t ctl;
  logic    rawSck;
  logic    cfgUnused;

  // source select and low-count fields are held by software only (R9)
  assign cfgUnused = ^{clkCfg[CFG_W-1:DIV_LSB+CNT_W], clkCfg[HI_LSB-1:0]};

  spi_sck_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .runReq (runReq),
    .ctl    (ctl)
  );

  spi_sck_datapath #(
    .CNT_W(CNT_W), .CFG_W(CFG_W), .DIV_LSB(DIV_LSB), .HI_LSB(HI_LSB)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .clkCfg     (clkCfg),
    .ctl        (ctl),
    .rawSck     (rawSck),
    .shiftStb   (shiftStb),
    .captureStb (captureStb)
  );

  assign sck = ctl.active ? (clkNotInv ? rawSck : !rawSck) : idleHigh;

  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.active) |-> (!shiftStb && !captureStb));
endmodule

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] clkCfg = '0;
  logic        runReq = 1'b0;
  logic        clkNotInv = 1'b1;
  logic        idleHigh = 1'b0;
  logic        sck, shiftStb, captureStb;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tagNow = "R1";

  // behavioural reference state
  int  mDiv = 1, mHi = 0, mCnt = 0;
  bit  mRun = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_sck_gen uut (
    .clk(clk), .rstN(rstN), .clkCfg(clkCfg), .runReq(runReq),
    .clkNotInv(clkNotInv), .idleHigh(idleHigh),
    .sck(sck), .shiftStb(shiftStb), .captureStb(captureStb)
  );

  function automatic logic [31:0] mkCfg(int src, int dv, int hi, int lo);
    return (32'(src) << 31) | (32'(dv & 63) << 12) | (32'(hi & 63) << 6) | 32'(lo & 63);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mCnt = 0; mDiv = 1; mHi = 0;
    end else if (!mRun && runReq) begin
      mDiv = (clkCfg[17:12] == 0) ? 1 : int'(clkCfg[17:12]);
      mHi  = (int'(clkCfg[11:6]) >= mDiv) ? mDiv - 1 : int'(clkCfg[11:6]);
      mCnt = 0;
      mRun = 1;
    end else if (mRun) begin
      mCnt = (mCnt == mDiv) ? 0 : mCnt + 1;
      mRun = runReq;
    end
  end

  task automatic check1(string what, logic got, logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %0b expected %0b at cycle %0d", tagNow, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      logic hiLvl;
      hiLvl = (mCnt <= mHi);
      check1("sck", sck, mRun ? (clkNotInv ? hiLvl : !hiLvl) : idleHigh);
      check1("shiftStb", shiftStb, mRun && mCnt == 0);
      check1("captureStb", captureStb, mRun && mCnt == mHi + 1);
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic runFor(int n);
    runReq = 1'b1; waitCyc(n);
    runReq = 1'b0; waitCyc(3);
  endtask

  initial begin
    tagNow = "R1";
    waitCyc(2);
    check1("reset sck", sck, 1'b0);
    check1("reset shiftStb", shiftStb, 1'b0);
    check1("reset captureStb", captureStb, 1'b0);
    rstN = 1'b1; waitCyc(3);

    // R2 R3 R5: typical n=4 -> div 4, high 1
    tagNow = "R2";
    clkCfg = mkCfg(0, 4, 1, 4);
    runFor(23);

    // R10: first cycle after start
    tagNow = "R10";
    clkCfg = mkCfg(0, 6, 2, 6);
    runReq = 1'b1; waitCyc(1);
    check1("first sck", sck, 1'b1);
    check1("first shiftStb", shiftStb, 1'b1);
    waitCyc(10); runReq = 1'b0; waitCyc(3);

    // R3 R5 asymmetric duty
    tagNow = "R3";
    clkCfg = mkCfg(0, 7, 5, 1);
    runFor(30);
    tagNow = "R5";
    clkCfg = mkCfg(0, 9, 0, 9);
    runFor(25);

    // R4 clamp: high > divider, high == divider, divider 0
    tagNow = "R4";
    clkCfg = mkCfg(0, 3, 40, 0); runFor(14);
    clkCfg = mkCfg(0, 5, 5, 0);  runFor(14);
    clkCfg = mkCfg(0, 0, 0, 0);  runFor(9);
    clkCfg = mkCfg(0, 0, 7, 3);  runFor(9);
    clkCfg = mkCfg(0, 63, 62, 0); runFor(140);

    // R6 inverted clock
    tagNow = "R6";
    clkNotInv = 1'b0;
    clkCfg = mkCfg(0, 4, 1, 4); runFor(17);
    clkNotInv = 1'b1;

    // R7 idle high and early stop mid-period, restart resets count
    tagNow = "R7";
    idleHigh = 1'b1; waitCyc(2);
    check1("idle high sck", sck, 1'b1);
    clkCfg = mkCfg(0, 8, 3, 8);
    runFor(5);
    runFor(2);
    runReq = 1'b1; waitCyc(1); runReq = 1'b0; waitCyc(1);
    check1("stopped sck", sck, 1'b1);
    idleHigh = 1'b0; waitCyc(2);

    // R8 rewrite config during run
    tagNow = "R8";
    clkCfg = mkCfg(0, 5, 2, 5);
    runReq = 1'b1; waitCyc(4);
    clkCfg = mkCfg(0, 2, 0, 2); waitCyc(8);
    clkCfg = mkCfg(0, 11, 9, 1); waitCyc(8);
    runReq = 1'b0; waitCyc(3);

    // R9 source select and low count do not matter
    tagNow = "R9";
    clkCfg = mkCfg(1, 4, 1, 17);
    runReq = 1'b1; waitCyc(7);
    clkCfg = mkCfg(0, 4, 1, 50); waitCyc(7);
    clkCfg = mkCfg(1, 4, 1, 0);  waitCyc(7);
    runReq = 1'b0; waitCyc(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule